// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits in the decode stage of an in-order pipeline whose execution units take different numbers of cycles to produce a result. Each cycle it looks at the instruction waiting to issue: its operation class, up to two source registers and an optional destination register, each tagged with the register file it belongs to (integer or floating point). It keeps a per-register countdown of results still in flight, a busy window for the unpipelined divider and a forward booking of the single floating-point write port. If issuing now would read a stale value, overtake an earlier writer, reuse the divider too soon or double-book the write port, it raises `stall` so fetch and decode hold the instruction.

A stalled instruction is offered again the next cycle, unchanged. Nothing is reserved for it until the cycle in which it actually issues. Because every operand carries its own file bit, an instruction that reads an integer base register while writing a floating-point register, or a move between the files, is checked against both files with no special case.

Top module: `issue_hazard_chk`

## Requirements
- R1: After reset no register is pending, the divider is free and no write-port slot is booked, so any valid instruction issues at once (`stall`=0, `issue`=1).
- R2: Operation class codes are ALU=0, LOAD=1, FADD=2, MUL=3 and DIV=4, with result latencies of 1, 2, 4, 7 and 25 cycles. An instruction that reads the destination of a producer issued in cycle t stalls through cycle t+L-1 and issues in cycle t+L, where L is the producer's latency.
- R3: A DIV issued in cycle t blocks any other DIV until cycle t+25. Over that window, instructions of other classes are not held back by the divider.
- R4: An instruction with a floating-point destination whose write cycle (issue cycle plus latency) is already booked on the floating-point write port stalls. It issues once that cycle is free.
- R5: An instruction whose destination still has a pending result from an earlier writer stalls until that result is ready.
- R6: The integer and floating-point files are tracked separately, so register n of one file never blocks on register n of the other. An operand's file bit (0 integer, 1 floating point) picks which file it is checked against.
- R7: Integer register 0 neither records a pending result nor makes a reader wait.
- R8: `issue` equals `dec_valid` and not `stall`. A stalled instruction books no register, divider or write-port slot.
- R9: While `dec_valid` is 0 no reservation is made, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is waiting to issue |
| dec_cls | input | 3 | Operation class code (see R2) |
| src_a_en | input | 1 | Source A is used |
| src_a_fp | input | 1 | Source A file: 0 integer, 1 floating point |
| src_a | input | 5 | Source A register index |
| src_b_en | input | 1 | Source B is used |
| src_b_fp | input | 1 | Source B file |
| src_b | input | 5 | Source B register index |
| dst_en | input | 1 | Instruction writes a destination |
| dst_fp | input | 1 | Destination file |
| dst | input | 5 | Destination register index |
| stall | output | 1 | Hold fetch and decode this cycle |
| issue | output | 1 | Instruction leaves decode this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers per file, latencies 1, 2, 4, 7 and 25, and a divider repeat interval of 25. These values make the longest countdown, the full divider window and a write-port clash between a multiply and a later add each short enough for a directed sequence to reach. The table walks every class as a producer and counts the exact number of stall cycles seen by a dependent reader. The directed cases then cover the two files, register 0, the divider gap, the write-port collision, a stalled or invalid instruction leaving nothing booked, and reset in the middle of a busy window.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

   typedef enum logic [2:0] {
      CLS_ALU  = 3'd0,
      CLS_LOAD = 3'd1,
      CLS_FADD = 3'd2,
      CLS_MUL  = 3'd3,
      CLS_DIV  = 3'd4
   } op_cls_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ihc_scoreboard.sv
module ihc_scoreboard #(
   parameter int NREG       = 32,
   parameter int CW         = 5,
   parameter bit ZERO_FIXED = 1'b0,
   localparam int IW        = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] qa_idx,
   input  logic [IW-1:0] qb_idx,
   input  logic [IW-1:0] qd_idx,
   output logic          qa_busy,
   output logic          qb_busy,
   output logic          qd_busy,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic [CW-1:0] set_val
);

   if (NREG != (1 << IW)) begin : g_bad_nreg
      $error("ihc_scoreboard: NREG must be a power of two");
   end
   if (CW < 1) begin : g_bad_cw
      $error("ihc_scoreboard: CW must be at least 1");
   end

   logic [CW-1:0] cnt [NREG];

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      if (ZERO_FIXED && e == 0) begin : g_zero
         assign cnt[e] = '0;
      end else begin : g_cnt
         logic hit;
         assign hit = set_en && (set_idx == IW'(e));

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt[e] <= '0;
            else if (hit)
               cnt[e] <= set_val;
            else if (cnt[e] != '0)
               cnt[e] <= cnt[e] - 1'b1;
         end

         // R2: a pending count falls by one each cycle until it is reloaded
         p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && cnt[e] != '0) |=> (cnt[e] == $past(cnt[e]) - 1'b1));
      end
   end

   assign qa_busy = (cnt[qa_idx] != '0);
   assign qb_busy = (cnt[qb_idx] != '0);
   assign qd_busy = (cnt[qd_idx] != '0);

endmodule

// File: rtl/ihc_div_gate.sv
module ihc_div_gate #(
   parameter int RPT = 25,
   localparam int DW = $clog2(RPT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);

   if (RPT < 2) begin : g_bad_rpt
      $error("ihc_div_gate: RPT must be at least 2");
   end

   logic [DW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left <= '0;
      else if (go)
         left <= DW'(RPT - 1);
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign busy = (left != '0);

   // R3: the issue logic never starts a divide inside the busy window
   p_div_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !go);

endmodule

// File: rtl/ihc_wport_sched.sv
module ihc_wport_sched #(
   parameter int MAXL = 25,
   localparam int LW  = $clog2(MAXL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] q_lat,
   output logic          clash,
   input  logic          book_en,
   input  logic [LW-1:0] book_lat
);

   if (MAXL < 2) begin : g_bad_maxl
      $error("ihc_wport_sched: MAXL must be at least 2");
   end

   // slot[j] set: the port is taken j cycles from now
   logic [MAXL:0] slot;
   logic [MAXL:0] slot_nx;

   assign slot_nx[0]    = 1'b0;
   assign slot_nx[MAXL] = 1'b0;
   for (genvar j = 1; j < MAXL; j++) begin : g_slot
      assign slot_nx[j] = slot[j+1] | (book_en && (book_lat == LW'(j + 1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot <= '0;
      else
         slot <= slot_nx;
   end

   assign clash = (int'(q_lat) <= MAXL) ? slot[q_lat] : 1'b0;

   // R4: bookings move one slot nearer each cycle
   p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot[2] |=> slot[1]);

   // R4: a booking is never placed on a slot already taken
   p_book_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      book_en |-> !clash);

endmodule

// File: rtl/issue_hazard_chk.sv
module issue_hazard_chk
   import ihc_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int LAT_ALU  = 1,
   parameter int LAT_LOAD = 2,
   parameter int LAT_FADD = 4,
   parameter int LAT_MUL  = 7,
   parameter int LAT_DIV  = 25,
   parameter int DIV_RPT  = 25,
   localparam int IW      = $clog2(NREG),
   localparam int MAXL    = max2(max2(max2(LAT_ALU, LAT_LOAD), max2(LAT_FADD, LAT_MUL)), LAT_DIV),
   localparam int CW      = $clog2(MAXL),
   localparam int LW      = $clog2(MAXL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_valid,
   input  logic [2:0]    dec_cls,
   input  logic          src_a_en,
   input  logic          src_a_fp,
   input  logic [IW-1:0] src_a,
   input  logic          src_b_en,
   input  logic          src_b_fp,
   input  logic [IW-1:0] src_b,
   input  logic          dst_en,
   input  logic          dst_fp,
   input  logic [IW-1:0] dst,
   output logic          stall,
   output logic          issue
);

   if (LAT_ALU < 1 || LAT_LOAD < 1 || LAT_FADD < 1 || LAT_MUL < 1 || LAT_DIV < 1) begin : g_bad_lat
      $error("issue_hazard_chk: every latency must be at least 1");
   end
   if (MAXL < 2) begin : g_bad_maxl
      $error("issue_hazard_chk: the longest latency must be at least 2");
   end

   logic [LW-1:0] lat;
   always_comb begin
      case (op_cls_e'(dec_cls))
         CLS_LOAD: lat = LW'(LAT_LOAD);
         CLS_FADD: lat = LW'(LAT_FADD);
         CLS_MUL:  lat = LW'(LAT_MUL);
         CLS_DIV:  lat = LW'(LAT_DIV);
         default:  lat = LW'(LAT_ALU);
      endcase
   end

   logic [1:0] a_busy, b_busy, d_busy, set_en;
   logic [CW-1:0] set_val;

   assign set_val = CW'(lat - LW'(1));

   // index 0: integer file, index 1: floating-point file
   for (genvar f = 0; f < 2; f++) begin : g_file
      assign set_en[f] = issue && dst_en && (dst_fp == f[0]);

      ihc_scoreboard #(
         .NREG       (NREG),
         .CW         (CW),
         .ZERO_FIXED (f == 0)
      ) i_sb (
         .clk     (clk),
         .rst_n   (rst_n),
         .qa_idx  (src_a),
         .qb_idx  (src_b),
         .qd_idx  (dst),
         .qa_busy (a_busy[f]),
         .qb_busy (b_busy[f]),
         .qd_busy (d_busy[f]),
         .set_en  (set_en[f]),
         .set_idx (dst),
         .set_val (set_val)
      );
   end

   logic is_div, div_busy, port_clash;
   logic raw_hz, waw_hz, div_hz, port_hz;

   assign is_div = (dec_cls == 3'(CLS_DIV));

   ihc_div_gate #(.RPT(DIV_RPT)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (issue && is_div),
      .busy  (div_busy)
   );

   ihc_wport_sched #(.MAXL(MAXL)) i_wport (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_lat    (lat),
      .clash    (port_clash),
      .book_en  (issue && dst_en && dst_fp),
      .book_lat (lat)
   );

   assign raw_hz  = (src_a_en && a_busy[src_a_fp]) || (src_b_en && b_busy[src_b_fp]);
   assign waw_hz  = dst_en && d_busy[dst_fp];
   assign div_hz  = is_div && div_busy;
   assign port_hz = dst_en && dst_fp && port_clash;

   assign stall = dec_valid && (raw_hz || waw_hz || div_hz || port_hz);
   assign issue = dec_valid && !stall;

endmodule

// File: tb/test_issue_hazard_chk.sv
module test_issue_hazard_chk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_valid = 1'b0;
   logic [2:0] dec_cls = 3'd0;
   logic       src_a_en = 1'b0, src_a_fp = 1'b0;
   logic [4:0] src_a = 5'd0;
   logic       src_b_en = 1'b0, src_b_fp = 1'b0;
   logic [4:0] src_b = 5'd0;
   logic       dst_en = 1'b0, dst_fp = 1'b0;
   logic [4:0] dst = 5'd0;
   logic       stall, issue;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   issue_hazard_chk i_issue_hazard_chk (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
      .src_a_en(src_a_en), .src_a_fp(src_a_fp), .src_a(src_a),
      .src_b_en(src_b_en), .src_b_fp(src_b_fp), .src_b(src_b),
      .dst_en(dst_en), .dst_fp(dst_fp), .dst(dst),
      .stall(stall), .issue(issue)
   );

   // entry: {producer class, expected stall cycles of a dependent reader}
   localparam logic [7:0] TBL [5] = '{
      {3'd0, 5'd0}, {3'd1, 5'd1}, {3'd2, 5'd3}, {3'd3, 5'd6}, {3'd4, 5'd24}
   };

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(input logic [2:0] c,
                      input logic ae, input logic af, input logic [4:0] a,
                      input logic be, input logic bf, input logic [4:0] b,
                      input logic de, input logic df, input logic [4:0] d);
      dec_valid = 1'b1; dec_cls = c;
      src_a_en = ae; src_a_fp = af; src_a = a;
      src_b_en = be; src_b_fp = bf; src_b = b;
      dst_en = de; dst_fp = df; dst = d;
   endtask

   task automatic idle(input int n);
      dec_valid = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   // held instruction: count stall cycles until it issues, then commit it
   task automatic wait_issue(output int n);
      n = 0;
      for (int k = 0; k < 40; k++) begin
         #1;
         if (!stall) break;
         n++;
         step();
      end
      step();
      dec_valid = 1'b0;
   endtask

   task automatic do_reset();
      dec_valid = 1'b0;
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int n;
      @(negedge clk);
      do_reset();

      // R1: fresh state, a divide reading and writing anything issues
      put(3'd4, 1, 0, 5'd3, 1, 1, 5'd4, 1, 1, 5'd5);
      #1;
      check("R1 stall after reset", stall, 0);
      check("R1 issue after reset", issue, 1);
      dec_valid = 1'b0;
      do_reset();

      // R2: each class as producer, reader offered from the next cycle
      for (int i = 0; i < 5; i++) begin
         put(TBL[i][7:5], 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'(i + 1));
         step();
         put(3'd0, 0, 0, 5'd0, 1, 0, 5'(i + 1), 1, 0, 5'd20);
         wait_issue(n);
         check($sformatf("R2 RAW stalls class %0d", i), n, int'(TBL[i][4:0]));
         idle(30);
      end

      // R3: second divide must wait for the divider, ALU work does not
      put(3'd4, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd5);
      step();
      put(3'd0, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd7);
      #1;
      check("R3 alu during divide", stall, 0);
      step();
      put(3'd4, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd6);
      wait_issue(n);
      check("R3 divide gap stalls", n, 23);
      idle(30);

      // R4: MUL to f1 writes at +7; FADD to f2 offered at +3 clashes once
      put(3'd3, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd1);
      step(); idle(2);
      put(3'd2, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd2);
      wait_issue(n);
      check("R4 write port clash stalls", n, 1);
      idle(30);
      // R4: same timing but integer destination, no port involved
      put(3'd3, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd1);
      step(); idle(2);
      put(3'd2, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd2);
      wait_issue(n);
      check("R4 integer dest no port stall", n, 0);
      idle(30);

      // R5: FADD to f4 then ALU writing f4
      put(3'd2, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd4);
      step();
      put(3'd0, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd4);
      wait_issue(n);
      check("R5 WAW stalls", n, 3);
      idle(30);

      // R6: FADD to f3 then reader of integer r3
      put(3'd2, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd3);
      step();
      put(3'd0, 1, 0, 5'd3, 0, 0, 5'd0, 1, 0, 5'd9);
      wait_issue(n);
      check("R6 files independent", n, 0);
      idle(30);
      // R6: MUL to r9 then FP load using r9 as base
      put(3'd3, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd9);
      step();
      put(3'd1, 1, 0, 5'd9, 0, 0, 5'd0, 1, 1, 5'd8);
      wait_issue(n);
      check("R6 cross-file base stalls", n, 6);
      idle(30);

      // R7: MUL to r0 then reader of r0
      put(3'd3, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd0);
      step();
      put(3'd0, 1, 0, 5'd0, 1, 0, 5'd0, 1, 0, 5'd0);
      wait_issue(n);
      check("R7 register zero free", n, 0);
      idle(30);

      // R8: divide to f12 stalled by busy divider, then withdrawn
      put(3'd4, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd10);
      step();
      put(3'd4, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd12);
      #1;
      check("R8 stalled divide", stall, 1);
      check("R8 no issue while stalled", issue, 0);
      step();
      put(3'd0, 1, 1, 5'd12, 0, 0, 5'd0, 1, 1, 5'd12);
      #1;
      check("R8 stalled instr reserved nothing", stall, 0);
      step();
      dec_valid = 1'b0;
      idle(30);

      // R9: invalid MUL to r11 then reader of r11
      put(3'd3, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd11);
      dec_valid = 1'b0;
      step();
      put(3'd0, 1, 0, 5'd11, 0, 0, 5'd0, 0, 0, 5'd0);
      #1;
      check("R9 invalid made no reservation", stall, 0);
      step();
      dec_valid = 1'b0;

      // R1: reset in the middle of a divide clears everything
      put(3'd4, 0, 0, 5'd0, 0, 0, 5'd0, 1, 1, 5'd13);
      step(); idle(2);
      do_reset();
      put(3'd4, 1, 1, 5'd13, 0, 0, 5'd0, 1, 1, 5'd13);
      #1;
      check("R1 reset clears busy state", stall, 0);
      step();
      dec_valid = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule